// File: doc/BRIEF.md
# Line Voltage Sag Detector

The block watches a stream of signed voltage samples and decides, one line cycle at a time, whether the supply has sagged. Each valid sample is reduced to an 8-bit magnitude level. The block keeps the largest level seen since the last cycle boundary. An external zero-crossing source marks the end of each line cycle with a one-clock pulse.

At each boundary the finished cycle is classed as low when its peak level is under the programmed threshold. A run counter counts consecutive low cycles. Once the run reaches the programmed cycle count, the sag output goes high and a one-clock event flag is raised for a status register elsewhere in the chip. A single low sample, or a run that is too short, has no effect. The first cycle whose peak reaches the threshold ends the run and releases the output.

A small write port loads the threshold and the cycle count. Any write restarts the run.

Top module: `sag_detector`

## Requirements
- R1: After reset, sag_o and sag_flag_o are 0, the threshold register is 0x00 and the cycle-count register is 0xFF. With a threshold of 0x00 no cycle is ever low, so sag_o stays 0.
- R2: The level of a sample is its absolute value, taken as bits [22:15] of that absolute value for a 24-bit sample. The full-scale negative value -2^23 saturates to level 0xFF.
- R3: The peak of a cycle is the largest level among the valid samples since the previous boundary, including a sample that is valid in the same clock as the boundary pulse. A cycle is low when its peak is strictly less than the threshold. At a boundary a low cycle increments the run counter, saturating at 255, and any other cycle clears it to 0.
- R4: sag_o rises in the clock after the boundary that ends the Nth consecutive low cycle, where N is the cycle-count register. Shorter runs and single low samples leave it at 0.
- R5: sag_o stays 1 while further low cycles follow. It returns to 0 in the clock after the first boundary whose cycle peak is at or above the threshold.
- R6: A write with wr_en_i=1 loads the threshold when wr_sel_i=0 and the cycle count when wr_sel_i=1, from wr_data_i. In the clock after any write, the run counter is 0 and sag_o is 0. A write takes precedence over a boundary pulse in the same clock.
- R7: A cycle count of 0 behaves as a count of 1.
- R8: sag_flag_o is high for exactly the one clock in which sag_o first becomes 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 24 | Signed voltage sample |
| sample_valid_i | input | 1 | sample_i is valid this clock |
| cycle_end_i | input | 1 | One-clock pulse marking the end of a line cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = threshold, 1 = cycle count |
| wr_data_i | input | 8 | Register write data |
| sag_o | output | 1 | Sag active |
| sag_flag_o | output | 1 | One-clock pulse when a sag starts |

## Verification
Every result of this block is due in the clock after the edge that takes a boundary pulse or a write. sag_o and sag_flag_o are both registered once behind the run decision. The bench registers each strobe it drives and compares the outputs at the falling edge that follows. Each expected value is taken from a queue filled by the driver, which models the threshold, the count and the run from the requirements. Boundaries and writes are spaced at least one clock apart, so each queued result pairs with exactly one stimulus.

// File: rtl/sag_pkg.sv
package sag_pkg;
  typedef enum logic {
    SEL_LEVEL  = 1'b0,
    SEL_CYCLES = 1'b1
  } sag_sel_e;
endpackage

// File: rtl/sag_level.sv
// Sample to magnitude level: abs value, top LEVEL_W magnitude bits.
module sag_level #(
  parameter int SAMPLE_W = 24,
  parameter int LEVEL_W  = 8
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [LEVEL_W-1:0]  level_o
);
  logic [SAMPLE_W-1:0] mag;

  assign mag = sample_i[SAMPLE_W-1] ? (~sample_i + 1'b1) : sample_i;

  generate
    if (SAMPLE_W - 1 >= LEVEL_W) begin : g_slice
      // only -full-scale keeps the sign bit after negation
      assign level_o = mag[SAMPLE_W-1] ? '1 : mag[SAMPLE_W-2 -: LEVEL_W];
    end else begin : g_pad
      logic [LEVEL_W-1:0] wide;
      assign wide    = LEVEL_W'(mag[SAMPLE_W-2:0]) << (LEVEL_W - SAMPLE_W + 1);
      assign level_o = mag[SAMPLE_W-1] ? '1 : wide;
    end
  endgenerate
endmodule

// File: rtl/sag_peak.sv
// Tracks the largest level within the current line cycle.
module sag_peak #(
  parameter int LEVEL_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [LEVEL_W-1:0] level_i,
  input  logic               cycle_end_i,
  output logic [LEVEL_W-1:0] cyc_peak_o
);
  logic [LEVEL_W-1:0] acc_q;

  // sample coincident with the boundary belongs to the ending cycle
  assign cyc_peak_o = (valid_i && (level_i > acc_q)) ? level_i : acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          acc_q <= '0;
    else if (cycle_end_i) acc_q <= '0;
    else if (valid_i)     acc_q <= cyc_peak_o;
  end
endmodule

// File: rtl/sag_cfg.sv
module sag_cfg
  import sag_pkg::*;
#(
  parameter int LEVEL_W = 8,
  parameter int CYC_W   = 8,
  parameter int DATA_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  sag_sel_e           wr_sel_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [LEVEL_W-1:0] thr_o,
  output logic [CYC_W-1:0]   ncyc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_o  <= '0;
      ncyc_o <= '1;
    end else if (wr_en_i) begin
      if (wr_sel_i == SEL_LEVEL) thr_o  <= wr_data_i[LEVEL_W-1:0];
      else                       ncyc_o <= wr_data_i[CYC_W-1:0];
    end
  end
endmodule

// File: rtl/sag_run.sv
// Consecutive low-cycle counter and sag output.
module sag_run #(
  parameter int LEVEL_W = 8,
  parameter int CYC_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               cycle_end_i,
  input  logic [LEVEL_W-1:0] cyc_peak_i,
  input  logic [LEVEL_W-1:0] thr_i,
  input  logic [CYC_W-1:0]   ncyc_i,
  output logic               sag_o,
  output logic               flag_o
);
  logic [CYC_W-1:0] cnt_q, cnt_nxt, cnt_inc, eff_cyc;
  logic             low, sag_nxt;

  assign low     = cyc_peak_i < thr_i;
  assign cnt_inc = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;
  assign eff_cyc = (ncyc_i == '0) ? CYC_W'(1) : ncyc_i;

  always_comb begin
    cnt_nxt = cnt_q;
    sag_nxt = sag_o;
    if (clear_i) begin
      cnt_nxt = '0;
      sag_nxt = 1'b0;
    end else if (cycle_end_i) begin
      cnt_nxt = low ? cnt_inc : '0;
      sag_nxt = cnt_nxt >= eff_cyc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sag_o  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      sag_o  <= sag_nxt;
      flag_o <= sag_nxt & ~sag_o;
    end
  end
endmodule

// File: rtl/sag_detector.sv
module sag_detector
  import sag_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int LEVEL_W  = 8,
  parameter int CYC_W    = 8,
  localparam int DATA_W  = (LEVEL_W > CYC_W) ? LEVEL_W : CYC_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                sample_valid_i,
  input  logic                cycle_end_i,
  input  logic                wr_en_i,
  input  logic                wr_sel_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic                sag_o,
  output logic                sag_flag_o
);
  logic [LEVEL_W-1:0] level, cyc_peak, thr;
  logic [CYC_W-1:0]   ncyc;
  sag_sel_e           sel;

  assign sel = sag_sel_e'(wr_sel_i);

  sag_level #(.SAMPLE_W(SAMPLE_W), .LEVEL_W(LEVEL_W)) u_level (
    .sample_i (sample_i),
    .level_o  (level)
  );

  sag_peak #(.LEVEL_W(LEVEL_W)) u_peak (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (sample_valid_i),
    .level_i     (level),
    .cycle_end_i (cycle_end_i),
    .cyc_peak_o  (cyc_peak)
  );

  sag_cfg #(.LEVEL_W(LEVEL_W), .CYC_W(CYC_W), .DATA_W(DATA_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (sel),
    .wr_data_i (wr_data_i),
    .thr_o     (thr),
    .ncyc_o    (ncyc)
  );

  sag_run #(.LEVEL_W(LEVEL_W), .CYC_W(CYC_W)) u_run (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (wr_en_i),
    .cycle_end_i (cycle_end_i),
    .cyc_peak_i  (cyc_peak),
    .thr_i       (thr),
    .ncyc_i      (ncyc),
    .sag_o       (sag_o),
    .flag_o      (sag_flag_o)
  );
endmodule

// File: rtl/sag_detector_chk.sv
module sag_detector_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cycle_end_i,
  input logic wr_en_i,
  input logic sag_o,
  input logic sag_flag_o
);
  p_wr_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (!sag_o && !sag_flag_o));

  p_rise_at_boundary_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sag_o) |-> $past(cycle_end_i));

  p_fall_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sag_o) |-> ($past(cycle_end_i) || $past(wr_en_i)));

  p_flag_on_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sag_flag_o |-> $rose(sag_o));

  p_rise_gives_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sag_o) |-> sag_flag_o);
endmodule

bind sag_detector sag_detector_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cycle_end_i (cycle_end_i),
  .wr_en_i     (wr_en_i),
  .sag_o       (sag_o),
  .sag_flag_o  (sag_flag_o)
);

// File: tb/sag_detector_test.sv
`timescale 1ns/1ps
module sag_detector_test;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic signed [23:0] sample = '0;
  logic               valid = 1'b0, cyc_end = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0]         wr_data = '0;
  logic               sag, flag;
  logic               due = 1'b0;

  typedef struct { bit sag; bit flag; string req; } exp_t;
  exp_t q[$];

  int n_run = 0, n_fail = 0;
  int m_thr = 0, m_n = 255, m_cnt = 0, m_peak = 0;
  bit m_sag = 0;

  always #10 clk = ~clk;

  sag_detector uut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .sample_valid_i(valid),
    .cycle_end_i(cyc_end), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .sag_o(sag), .sag_flag_o(flag)
  );

  function automatic int lvl(input logic signed [23:0] s);
    int v, a;
    v = int'(s);
    a = (v < 0) ? -v : v;
    if (a >= (1 << 23)) return 255;
    return (a >> 15) & 255;
  endfunction

  task automatic check(input bit got, input bit exp, input string what);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", what, got, exp);
    end
  endtask

  // scoreboard monitor: a result is due one clock after each strobe
  always @(posedge clk) due <= cyc_end | wr_en;
  always @(negedge clk) begin
    if (rst_n && due) begin
      if (q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL scoreboard: result with no expected item");
      end else begin
        exp_t e;
        e = q.pop_front();
        check(sag, e.sag, {e.req, " sag_o"});
        check(flag, e.flag, {e.req, " sag_flag_o"});
      end
    end
  end

  task automatic put_sample(input logic signed [23:0] s);
    @(negedge clk);
    sample = s; valid = 1'b1;
    if (lvl(s) > m_peak) m_peak = lvl(s);
    @(negedge clk);
    valid = 1'b0;
  endtask

  // one strobe clock: boundary and/or write, optional coincident sample
  task automatic step(input bit be, input bit ws, input logic signed [23:0] s,
                      input bit we, input bit sel, input int data, input string req);
    exp_t e;
    bit nsag;
    @(negedge clk);
    cyc_end = be;
    if (ws) begin
      sample = s; valid = 1'b1;
      if (lvl(s) > m_peak) m_peak = lvl(s);
    end
    wr_en = we; wr_sel = sel; wr_data = data[7:0];
    if (we) begin
      if (sel) m_n = data; else m_thr = data;
      m_cnt = 0; nsag = 0;
    end else begin
      if (m_peak < m_thr) m_cnt = (m_cnt == 255) ? 255 : m_cnt + 1;
      else m_cnt = 0;
      nsag = m_cnt >= ((m_n == 0) ? 1 : m_n);
    end
    if (be) m_peak = 0;
    e.sag = nsag; e.flag = nsag & ~m_sag; e.req = req;
    m_sag = nsag;
    q.push_back(e);
    @(negedge clk);
    cyc_end = 1'b0; valid = 1'b0; wr_en = 1'b0;
  endtask

  task automatic wr(input bit sel, input int data, input string req);
    step(1'b0, 1'b0, '0, 1'b1, sel, data, req);
  endtask

  task automatic bnd(input string req);
    step(1'b1, 1'b0, '0, 1'b0, 1'b0, 0, req);
  endtask

  task automatic cyc(input int l, input string req);
    put_sample(24'sh100000);
    put_sample(-24'(l << 15));
    put_sample(24'sh080000);
    bnd(req);
  endtask

  initial begin
    #(200000 * 20);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sag, 1'b0, "R1 reset sag_o");
    check(flag, 1'b0, "R1 reset sag_flag_o");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(sag, 1'b0, "R1 after reset sag_o");

    // default threshold 0x00: nothing is low
    wr(1'b1, 1, "R6 write count");
    bnd("R1 thr zero");
    cyc(0, "R1 thr zero");
    bnd("R1 thr zero");

    wr(1'b0, 8'h40, "R6 write thr");
    wr(1'b1, 3, "R6 write count");
    put_sample(24'sh010000);
    bnd("R4 run 1 of 3");
    cyc(8'h10, "R4 run 2 of 3");
    cyc(8'h3F, "R4 run 3 of 3 rises");
    cyc(8'h20, "R5 stays");
    cyc(8'h50, "R5 release on high cycle");
    cyc(8'h10, "R3 restart 1");
    cyc(8'h10, "R3 restart 2");
    cyc(8'h40, "R3 equal level clears");
    cyc(8'h10, "R3 again 1");
    cyc(8'h10, "R3 again 2");
    cyc(8'h10, "R4 again 3");
    wr(1'b0, 8'h40, "R6 write clears sag");
    cyc(8'h10, "R6 run restarted 1");
    cyc(8'h10, "R6 run restarted 2");
    put_sample(24'sh010000);
    step(1'b1, 1'b0, '0, 1'b1, 1'b1, 3, "R6 write beats boundary");
    cyc(8'h10, "R6 after coincident 1");
    cyc(8'h10, "R6 after coincident 2");
    cyc(8'h10, "R6 after coincident 3");

    // coincident sample belongs to the ending cycle
    put_sample(24'sh010000);
    step(1'b1, 1'b1, 24'sh3F0000, 1'b0, 1'b0, 0, "R3 boundary sample counts");

    wr(1'b1, 0, "R7 write count zero");
    cyc(8'h10, "R7 count zero acts as one");
    cyc(8'h60, "R5 release");

    // magnitude extraction
    wr(1'b1, 1, "R2 count one");
    put_sample(-24'sh200000);
    bnd("R2 abs level 0x40 not low");
    put_sample(-24'sh1FFFFF);
    bnd("R2 abs level 0x3F low");
    wr(1'b0, 8'hFF, "R2 thr FF");
    put_sample(-24'sh7FFFFF - 24'sh1);
    bnd("R2 full-scale negative saturates");
    put_sample(24'sh7F7FFF);
    bnd("R2 level FE low");
    put_sample(24'sh7FFFFF);
    bnd("R2 positive max not low");

    repeat (3) @(negedge clk);
    n_run++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: %0d results missing, expected 0", q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule